// File: doc/BRIEF.md
# Quadrature Divide-by-Four Clock Generator

This block turns a stream of single-cycle enable ticks into two square waves at one quarter of the tick rate. The two waves have the same frequency and sit a quarter period apart: the in-phase wave leads the quadrature wave by one tick, or 90 degrees. A typical use is as the reference divider in a phase-locked pilot regenerator. There, a 76 kHz oscillator tick gives two 19 kHz phases, and one of those phases is locked to the received pilot.

The divider is a two-stage twisted ring. The in-phase stage loads the inverse of the quadrature stage, and the quadrature stage loads the in-phase stage. The state therefore walks a four-step Gray cycle, and exactly one output changes on each tick. Every one of the four 2-bit states lies on that cycle, so there is no state from which the ring can fail to rejoin the sequence. A synchronous reset returns both outputs to low.

Top module: `quad_div4_gen`

## Requirements
- R1: When `rst` is high at a rising clock edge, both `out_i` and `out_q` are 0 after that edge.
- R2: When `rst` is low and `tick_en` is low at an edge, neither output changes at that edge.
- R3: On a tick (`rst` low, `tick_en` high), the new `out_i` equals the inverse of the `out_q` value before the edge.
- R4: Starting from reset, successive ticks give the pair {`out_q`,`out_i`} the values 01, 11, 10, 00, and the cycle then repeats.
- R5: Each output is high for exactly two of every four consecutive ticks and repeats with a period of four ticks.
- R6: On a tick, the new `out_q` equals the `out_i` value before the edge, so the quadrature output lags the in-phase output by one tick.
- R7: Reset takes priority over a tick that arrives in the same cycle.
- R8: On every tick exactly one of the two outputs toggles. From any starting state the next tick follows R3 and R6, so no state locks the ring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Input-rate enable; each high cycle advances the ring one step |
| out_i | output | 1 | In-phase square wave at one quarter of the tick rate |
| out_q | output | 1 | Quadrature square wave, one tick behind `out_i` |

## Verification
The properties assume that `tick_en` is a plain level sampled at each rising edge. They require no spacing between ticks, so back-to-back ticks, isolated ticks and long idle gaps are all legal and all are covered. The properties also assume that `rst` is driven synchronously and is high at the first clock edge. The stimulus drives both inputs only at the falling edge and holds reset through the first edges. The random tick density is varied from sparse to continuous, and reset is sometimes raised in the same cycle as a tick.

// File: rtl/quad_div4_pkg.sv
package quad_div4_pkg;

    // Ring state: one flip-flop per phase
    typedef struct packed {
        logic q;   // quadrature stage
        logic i;   // in-phase stage
    } ring_t;

    localparam int RING_W     = $bits(ring_t);
    localparam int DIV_FACTOR = 2 * RING_W;   // twisted ring of N stages divides by 2N

    localparam ring_t RING_IDLE = '{q: 1'b0, i: 1'b0};

endpackage

// File: rtl/quad_ring_step.sv
// Next state of the twisted ring for one advance.
module quad_ring_step
    import quad_div4_pkg::*;
(
    input  ring_t cur,
    output ring_t nxt
);
    always_comb begin
        nxt.i = ~cur.q;   // twist: inverted feedback from the last stage
        nxt.q = cur.i;    // shift: quadrature follows in-phase
    end
endmodule

// File: rtl/quad_ring_sel.sv
// Chooses among reset, advance and hold for the registered ring.
module quad_ring_sel
    import quad_div4_pkg::*;
(
    input  logic  clr,
    input  logic  adv,
    input  ring_t cur,
    input  ring_t stepped,
    output ring_t sel
);
    always_comb begin
        if (clr)      sel = RING_IDLE;
        else if (adv) sel = stepped;
        else          sel = cur;
    end
endmodule

// File: rtl/quad_div4_gen.sv
module quad_div4_gen
    import quad_div4_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    output logic out_i,
    output logic out_q
);
    ring_t ring_q;
    ring_t ring_d;
    ring_t ring_step;

    quad_ring_step u_step (
        .cur (ring_q),
        .nxt (ring_step)
    );

    quad_ring_sel u_sel (
        .clr     (rst),
        .adv     (tick_en),
        .cur     (ring_q),
        .stepped (ring_step),
        .sel     (ring_d)
    );

    always_ff @(posedge clk) begin
        ring_q <= ring_d;
    end

    assign out_i = ring_q.i;
    assign out_q = ring_q.q;
endmodule

// File: rtl/quad_div4_gen_chk.sv
module quad_div4_gen_chk (
    input logic clk,
    input logic rst,
    input logic tick_en,
    input logic out_i,
    input logic out_q
);
    logic seen_edge;
    always_ff @(posedge clk) seen_edge <= 1'b1;

    always @(posedge clk) begin
        if (seen_edge === 1'b1 && $past(rst))
            AST_RESET_CLEARS: assert (!out_i && !out_q); // R1
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!tick_en) |=> $stable({out_q, out_i})); // R2

    AST_I_TAKES_NOT_Q: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> (out_i == !$past(out_q))); // R3

    AST_Q_TRAILS_I: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> (out_q == $past(out_i))); // R6

    AST_ONE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> ($countones({out_q, out_i} ^ $past({out_q, out_i})) == 1)); // R8
endmodule

bind quad_div4_gen quad_div4_gen_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .out_i   (out_i),
    .out_q   (out_q)
);

// File: tb/quad_div4_gen_tb.sv
module quad_div4_gen_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0;
    logic out_i, out_q;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic exp_i = 1'b0;
    logic exp_q = 1'b0;

    always #5 clk = ~clk;

    quad_div4_gen u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .out_i(out_i), .out_q(out_q)
    );

    function automatic logic [1:0] model_next(logic [1:0] qi, logic r, logic t);
        if (r)      return 2'b00;
        else if (t) return {qi[0], ~qi[1]};
        else        return qi;
    endfunction

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual q,i=%b expected q,i=%b", req, act, exp);
        end
    endtask

    // drive at the falling edge, sample 1 ns after the rising edge
    task automatic step(logic r, logic t, string req);
        logic [1:0] nx;
        @(negedge clk);
        rst = r;
        tick_en = t;
        nx = model_next({exp_q, exp_i}, r, t);
        @(posedge clk);
        #1;
        {exp_q, exp_i} = nx;
        check(req, {out_q, out_i}, {exp_q, exp_i});
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual running expected done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int hi_i;
        int hi_q;
        void'($urandom(32'd1357));
        // R1: reset state
        step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b1, "R7");
        // R4 sequence from reset: 01,11,10,00 twice
        for (int k = 0; k < 8; k++) begin
            step(1'b0, 1'b1, "R4");
        end
        // R5: two high of four ticks for each output
        hi_i = 0; hi_q = 0;
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 1'b1, "R5");
            hi_i += out_i; hi_q += out_q;
        end
        total++;
        if (hi_i != 2 || hi_q != 2) begin
            bad++;
            $display("FAIL R5: actual hi_i=%0d hi_q=%0d expected 2 and 2", hi_i, hi_q);
        end
        // R2: idle hold from a non-zero state
        step(1'b0, 1'b1, "R3");
        for (int k = 0; k < 5; k++) step(1'b0, 1'b0, "R2");
        // R7: reset with a tick from state 11
        step(1'b0, 1'b1, "R6");
        step(1'b1, 1'b1, "R7");
        step(1'b0, 1'b0, "R1");
        // random phase: varying tick density and occasional reset
        for (int blk = 0; blk < 8; blk++) begin
            int dens = (blk * 13) % 101;
            for (int k = 0; k < 300; k++) begin
                logic t = (($urandom % 100) < dens);
                logic r = (($urandom % 200) == 0);
                step(r, t, r ? "R7" : (t ? "R8" : "R2"));
            end
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule